// File: doc/BRIEF.md
# Inter-processor interrupt target resolver

This block turns one inter-processor interrupt command into the set of agents that must receive it. The sender presents its two command words with a valid strobe. The block decodes the shorthand, the addressing mode, the delivery mode and the destination byte. It then matches the destination against every agent's logical byte and format word and returns an N-bit target mask. The block does not deliver vectors and does not act on startup or init commands. It only decides who is addressed.

Each agent is matched in one of three ways: by physical index, by flat logical matching or by clustered logical matching. A shorthand code can replace the destination entirely. When the delivery mode asks for the lowest-priority target, the mask is cut down to its lowest-indexed member.

The command input and the mask output both use valid/ready. A command is accepted on any rising edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high whenever the output register is empty or the consumer is taking its contents on that edge. A produced mask stays on `tgt_mask`, unchanged and with `tgt_valid` high, until `tgt_ready` is seen high.

Top module: `ipi_target_resolver`

## Requirements
- R1: After reset, `tgt_valid` is low, `tgt_mask` is all zeros and `cmd_ready` is high.
- R2: A command accepted on one edge appears on `tgt_mask` with `tgt_valid` high after that same edge. While `tgt_valid` is high and `tgt_ready` is low, `cmd_ready` is low and `tgt_mask` and `tgt_valid` hold. Once the output is taken with no new command, `tgt_valid` falls.
- R3: Command fields are decoded as follows: shorthand from `cmd_lo[19:18]`, addressing mode from `cmd_lo[11]` (0 physical, 1 logical), delivery mode from `cmd_lo[10:8]`, destination byte from `cmd_hi[31:24]`. The vector in `cmd_lo[7:0]` has no effect on the mask.
- R4: With shorthand 0 and physical mode, destination 0xFF selects every agent. Any other value selects only agent number `dest`, or no agent if `dest` is not below N.
- R5: With shorthand 0 and logical mode, an agent whose format word has bits 31:28 equal to 0xF matches when `dest` AND its logical byte is nonzero. The logical byte is bits 31:24 of that agent's logical word.
- R6: With shorthand 0 and logical mode, an agent with format nibble 0x0 matches when the upper nibbles of `dest` and its logical byte are equal and the AND of the lower nibbles is nonzero.
- R7: An agent whose format nibble is neither 0xF nor 0x0 never matches a logical destination.
- R8: Shorthand 1 selects only the agent whose index equals `self_id`. If `self_id` is not below N, it selects no agent.
- R9: Shorthand 2 selects every agent, including the sender.
- R10: Shorthand 3 selects every agent except the one whose index equals `self_id`.
- R11: Delivery mode 3'b001 (lowest priority) keeps only the lowest-indexed set bit of the mask. Every other delivery mode passes the whole mask.
- R12: With a nonzero shorthand, the destination byte and the addressing mode have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command words are valid |
| cmd_ready | output | 1 | Block can accept a command this cycle |
| cmd_lo | input | 32 | Lower command word (shorthand, mode, delivery mode, vector) |
| cmd_hi | input | 32 | Upper command word (destination byte in 31:24) |
| self_id | input | ID_W | Index of the sending agent |
| agent_ldr | input | N*32 | Per-agent logical word, agent i at bits i*32 +: 32 |
| agent_dfr | input | N*32 | Per-agent format word, agent i at bits i*32 +: 32 |
| tgt_valid | output | 1 | Target mask is valid |
| tgt_ready | input | 1 | Consumer takes the mask this cycle |
| tgt_mask | output | N | Resolved target agents, bit i for agent i |

## Verification
The assertions assume two things about the inputs. First, `self_id`, `agent_ldr` and `agent_dfr` are steady from the cycle a command is accepted until its mask appears. Second, the command words stay unchanged while `cmd_valid` waits for `cmd_ready`. The per-command checks relate a property of the mask to the command accepted one edge earlier, so they depend on the first assumption. The stimulus meets both: it changes agent configuration only while no command is in flight, and during the stall scenario it holds the waiting command's words unchanged until the block accepts it.

// File: rtl/ipi_res_pkg.sv
package ipi_res_pkg;

  // Field positions inside the command words and per-agent words.
  localparam int SH_LSB   = 18;
  localparam int MODE_BIT = 11;
  localparam int DLV_LSB  = 8;
  localparam int DST_LSB  = 24;
  localparam int LDST_LSB = 24;
  localparam int FMT_LSB  = 28;

  localparam logic [3:0] FMT_FLAT    = 4'hF;
  localparam logic [3:0] FMT_CLUSTER = 4'h0;
  localparam logic [7:0] DEST_BCAST  = 8'hFF;

  typedef enum logic [1:0] {
    SH_FIELD  = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  typedef enum logic [2:0] {
    DLV_FIXED  = 3'd0,
    DLV_LOWEST = 3'd1,
    DLV_OTHER2 = 3'd2,
    DLV_OTHER3 = 3'd3,
    DLV_OTHER4 = 3'd4,
    DLV_OTHER5 = 3'd5,
    DLV_OTHER6 = 3'd6,
    DLV_OTHER7 = 3'd7
  } delivery_e;

  typedef struct packed {
    shorthand_e sh;
    logic       logical;
    delivery_e  dlv;
    logic [7:0] dest;
  } ipi_cmd_t;

endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
  import ipi_res_pkg::*;
(
  input  logic [31:0] cmd_lo,
  input  logic [31:0] cmd_hi,
  output ipi_cmd_t    cmd
);
  logic unused_cmd_bits;

  always_comb begin
    cmd.sh      = shorthand_e'(cmd_lo[SH_LSB +: 2]);
    cmd.logical = cmd_lo[MODE_BIT];
    cmd.dlv     = delivery_e'(cmd_lo[DLV_LSB +: 3]);
    cmd.dest    = cmd_hi[DST_LSB +: 8];
  end

  // Vector and reserved bits do not steer the target set.
  assign unused_cmd_bits = ^{cmd_lo[31:20], cmd_lo[17:12], cmd_lo[7:0], cmd_hi[23:0]};
endmodule

// File: rtl/ipi_logical_match.sv
module ipi_logical_match
  import ipi_res_pkg::*;
#(
  parameter int NUM_AGENTS = 8
) (
  input  logic [7:0]               dest,
  input  logic [NUM_AGENTS*32-1:0] agent_ldr,
  input  logic [NUM_AGENTS*32-1:0] agent_dfr,
  output logic [NUM_AGENTS-1:0]    hit
);
  for (genvar i = 0; i < NUM_AGENTS; i++) begin : g_agent
    logic [7:0] ldest;
    logic [3:0] fmt;
    logic       flat_hit;
    logic       clus_hit;
    logic       unused_agent_bits;

    assign ldest    = agent_ldr[i*32 + LDST_LSB +: 8];
    assign fmt      = agent_dfr[i*32 + FMT_LSB +: 4];
    assign flat_hit = |(dest & ldest);
    assign clus_hit = (dest[7:4] == ldest[7:4]) && (|(dest[3:0] & ldest[3:0]));

    always_comb begin
      unique case (fmt)
        FMT_FLAT:    hit[i] = flat_hit;
        FMT_CLUSTER: hit[i] = clus_hit;
        default:     hit[i] = 1'b0;
      endcase
    end

    assign unused_agent_bits = ^{agent_ldr[i*32 +: LDST_LSB], agent_dfr[i*32 +: FMT_LSB]};
  end
endmodule

// File: rtl/ipi_dest_select.sv
module ipi_dest_select
  import ipi_res_pkg::*;
#(
  parameter int NUM_AGENTS = 8,
  parameter int ID_W       = 8
) (
  input  ipi_cmd_t              cmd,
  input  logic [ID_W-1:0]       self_id,
  input  logic [NUM_AGENTS-1:0] log_hit,
  output logic [NUM_AGENTS-1:0] raw_mask
);
  logic [NUM_AGENTS-1:0] phys_hit;
  logic [NUM_AGENTS-1:0] self_bit;
  logic [NUM_AGENTS-1:0] field_mask;
  logic                  bcast;

  assign bcast = (cmd.dest == DEST_BCAST);

  for (genvar i = 0; i < NUM_AGENTS; i++) begin : g_idx
    assign phys_hit[i] = bcast || (32'(cmd.dest) == i);
    assign self_bit[i] = (32'(self_id) == i);
  end

  assign field_mask = cmd.logical ? log_hit : phys_hit;

  always_comb begin
    unique case (cmd.sh)
      SH_FIELD:  raw_mask = field_mask;
      SH_SELF:   raw_mask = self_bit;
      SH_ALL:    raw_mask = '1;
      SH_OTHERS: raw_mask = ~self_bit;
      default:   raw_mask = '0;
    endcase
  end
endmodule

// File: rtl/ipi_lowest_pick.sv
module ipi_lowest_pick #(
  parameter int NUM_AGENTS = 8
) (
  input  logic                  enable,
  input  logic [NUM_AGENTS-1:0] mask_in,
  output logic [NUM_AGENTS-1:0] mask_out
);
  logic [NUM_AGENTS-1:0] lowest;

  // Isolate the lowest set bit: x & (-x).
  assign lowest   = mask_in & (~mask_in + NUM_AGENTS'(1));
  assign mask_out = enable ? lowest : mask_in;
endmodule

// File: rtl/ipi_target_resolver.sv
module ipi_target_resolver
  import ipi_res_pkg::*;
#(
  parameter int NUM_AGENTS = 8,
  parameter int ID_W       = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  output logic                       cmd_ready,
  input  logic [31:0]                cmd_lo,
  input  logic [31:0]                cmd_hi,
  input  logic [ID_W-1:0]            self_id,
  input  logic [NUM_AGENTS*32-1:0]   agent_ldr,
  input  logic [NUM_AGENTS*32-1:0]   agent_dfr,
  output logic                       tgt_valid,
  input  logic                       tgt_ready,
  output logic [NUM_AGENTS-1:0]      tgt_mask
);
  ipi_cmd_t              cmd;
  logic [NUM_AGENTS-1:0] log_hit;
  logic [NUM_AGENTS-1:0] raw_mask;
  logic [NUM_AGENTS-1:0] next_mask;
  logic                  out_v;
  logic [NUM_AGENTS-1:0] out_mask;

  ipi_cmd_decode u_dec (
    .cmd_lo (cmd_lo),
    .cmd_hi (cmd_hi),
    .cmd    (cmd)
  );

  ipi_logical_match #(.NUM_AGENTS(NUM_AGENTS)) u_log (
    .dest      (cmd.dest),
    .agent_ldr (agent_ldr),
    .agent_dfr (agent_dfr),
    .hit       (log_hit)
  );

  ipi_dest_select #(.NUM_AGENTS(NUM_AGENTS), .ID_W(ID_W)) u_sel (
    .cmd      (cmd),
    .self_id  (self_id),
    .log_hit  (log_hit),
    .raw_mask (raw_mask)
  );

  ipi_lowest_pick #(.NUM_AGENTS(NUM_AGENTS)) u_pick (
    .enable   (cmd.dlv == DLV_LOWEST),
    .mask_in  (raw_mask),
    .mask_out (next_mask)
  );

  assign cmd_ready = !out_v || tgt_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_v    <= 1'b0;
      out_mask <= '0;
    end else if (cmd_ready) begin
      out_v <= cmd_valid;
      if (cmd_valid) out_mask <= next_mask;
    end
  end

  assign tgt_valid = out_v;
  assign tgt_mask  = out_mask;
endmodule

// File: rtl/ipi_target_resolver_chk.sv
module ipi_target_resolver_chk #(
  parameter int NUM_AGENTS = 8,
  parameter int ID_W       = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cmd_valid,
  input logic                  cmd_ready,
  input logic [31:0]           cmd_lo,
  input logic [ID_W-1:0]       self_id,
  input logic                  tgt_valid,
  input logic                  tgt_ready,
  input logic [NUM_AGENTS-1:0] tgt_mask
);
  logic                  accept;
  logic [NUM_AGENTS-1:0] self_bit;

  assign accept = cmd_valid && cmd_ready;

  always_comb begin
    self_bit = '0;
    for (int i = 0; i < NUM_AGENTS; i++) begin
      if (32'(self_id) == i) self_bit[i] = 1'b1;
    end
  end

  AST_VALID_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> tgt_valid); // R2

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_valid && !tgt_ready) |=> (tgt_valid && $stable(tgt_mask))); // R2

  AST_IDLE_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tgt_valid && !cmd_valid) |=> !tgt_valid); // R2

  AST_LOWEST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_lo[10:8] == 3'd1) |=> $onehot0(tgt_mask)); // R11

  AST_SELF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_lo[19:18] == 2'd1) |=> (tgt_mask == $past(self_bit))); // R8

  AST_OTHERS_SKIP_SELF: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_lo[19:18] == 2'd3) |=> ((tgt_mask & $past(self_bit)) == '0)); // R10
endmodule

bind ipi_target_resolver ipi_target_resolver_chk #(
  .NUM_AGENTS (NUM_AGENTS),
  .ID_W       (ID_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_lo    (cmd_lo),
  .self_id   (self_id),
  .tgt_valid (tgt_valid),
  .tgt_ready (tgt_ready),
  .tgt_mask  (tgt_mask)
);

// File: tb/ipi_target_resolver_test.sv
`timescale 1ns/1ps
module ipi_target_resolver_test;
  localparam int N = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [31:0]   cmd_lo = '0;
  logic [31:0]   cmd_hi = '0;
  logic [7:0]    self_id = '0;
  logic [N*32-1:0] agent_ldr = '0;
  logic [N*32-1:0] agent_dfr = '0;
  logic          tgt_valid;
  logic          tgt_ready = 1'b1;
  logic [N-1:0]  tgt_mask;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ipi_target_resolver #(.NUM_AGENTS(N), .ID_W(8)) uut (
    .clk (clk), .rst_n (rst_n),
    .cmd_valid (cmd_valid), .cmd_ready (cmd_ready),
    .cmd_lo (cmd_lo), .cmd_hi (cmd_hi), .self_id (self_id),
    .agent_ldr (agent_ldr), .agent_dfr (agent_dfr),
    .tgt_valid (tgt_valid), .tgt_ready (tgt_ready), .tgt_mask (tgt_mask)
  );

  function automatic logic [31:0] mk_lo(logic [1:0] sh, logic lg, logic [2:0] dlv, logic [7:0] vec);
    return {12'h0, sh, 6'h0, lg, dlv, vec};
  endfunction

  function automatic logic [31:0] mk_hi(logic [7:0] dest);
    return {dest, 24'h0};
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic set_agent(int i, logic [7:0] ldest, logic [3:0] fmt);
    agent_ldr[i*32 +: 32] = {ldest, 24'hA5A5A5};
    agent_dfr[i*32 +: 32] = {fmt, 28'hFFFFFFF};
  endtask

  // Issue one command with the consumer ready and return the resolved mask.
  task automatic issue(logic [31:0] lo, logic [31:0] hi, output logic [N-1:0] m);
    @(negedge clk);
    cmd_lo = lo; cmd_hi = hi; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R2 valid", {31'h0, tgt_valid}, 32'h1);
    m = tgt_mask;
  endtask

  task automatic t_reset();
    check("R1 valid", {31'h0, tgt_valid}, 32'h0);
    check("R1 mask", {24'h0, tgt_mask}, 32'h0);
    check("R1 ready", {31'h0, cmd_ready}, 32'h1);
  endtask

  task automatic t_physical();
    logic [N-1:0] m;
    issue(mk_lo(2'd0, 1'b0, 3'd0, 8'h00), mk_hi(8'd3), m); check("R4 dest 3", {24'h0, m}, 32'h08);
    issue(mk_lo(2'd0, 1'b0, 3'd0, 8'h00), mk_hi(8'hFF), m); check("R4 bcast", {24'h0, m}, 32'hFF);
    issue(mk_lo(2'd0, 1'b0, 3'd0, 8'h00), mk_hi(8'd9), m); check("R4 out of range", {24'h0, m}, 32'h00);
    issue(mk_lo(2'd0, 1'b0, 3'd0, 8'hAB), mk_hi(8'd6), m); check("R3 vector ignored", {24'h0, m}, 32'h40);
    issue({12'hFFF, 2'd0, 6'h3F, 1'b0, 3'd0, 8'hFF}, {8'd1, 24'hFFFFFF}, m);
    check("R3 reserved ignored", {24'h0, m}, 32'h02);
  endtask

  task automatic t_flat();
    logic [N-1:0] m;
    for (int i = 0; i < N; i++) set_agent(i, 8'(1 << i), 4'hF);
    issue(mk_lo(2'd0, 1'b1, 3'd0, 8'h00), mk_hi(8'h05), m); check("R5 flat 05", {24'h0, m}, 32'h05);
    issue(mk_lo(2'd0, 1'b1, 3'd0, 8'h00), mk_hi(8'h00), m); check("R5 flat none", {24'h0, m}, 32'h00);
    set_agent(2, 8'h04, 4'h5);
    issue(mk_lo(2'd0, 1'b1, 3'd0, 8'h00), mk_hi(8'hFF), m); check("R7 bad format", {24'h0, m}, 32'hFB);
  endtask

  task automatic t_cluster();
    logic [N-1:0] m;
    for (int i = 0; i < 4; i++) set_agent(i, {4'h1, 4'(1 << i)}, 4'h0);
    for (int i = 4; i < N; i++) set_agent(i, {4'h2, 4'(1 << (i - 4))}, 4'h0);
    issue(mk_lo(2'd0, 1'b1, 3'd0, 8'h00), mk_hi(8'h13), m); check("R6 cluster 13", {24'h0, m}, 32'h03);
    issue(mk_lo(2'd0, 1'b1, 3'd0, 8'h00), mk_hi(8'h28), m); check("R6 cluster 28", {24'h0, m}, 32'h80);
    issue(mk_lo(2'd0, 1'b1, 3'd0, 8'h00), mk_hi(8'h30), m); check("R6 no cluster", {24'h0, m}, 32'h00);
  endtask

  task automatic t_shorthand();
    logic [N-1:0] m;
    self_id = 8'd5;
    issue(mk_lo(2'd1, 1'b0, 3'd0, 8'h00), mk_hi(8'd2), m); check("R8 self", {24'h0, m}, 32'h20);
    issue(mk_lo(2'd2, 1'b0, 3'd0, 8'h00), mk_hi(8'd3), m); check("R9 all", {24'h0, m}, 32'hFF);
    issue(mk_lo(2'd3, 1'b0, 3'd0, 8'h00), mk_hi(8'hFF), m); check("R10 others", {24'h0, m}, 32'hDF);
    issue(mk_lo(2'd2, 1'b1, 3'd0, 8'h00), mk_hi(8'h30), m); check("R12 logical dest ignored", {24'h0, m}, 32'hFF);
    self_id = 8'd12;
    issue(mk_lo(2'd1, 1'b0, 3'd0, 8'h00), mk_hi(8'd1), m); check("R8 self out of range", {24'h0, m}, 32'h00);
    self_id = 8'd0;
  endtask

  task automatic t_lowest();
    logic [N-1:0] m;
    for (int i = 0; i < N; i++) set_agent(i, 8'(1 << i), 4'hF);
    issue(mk_lo(2'd0, 1'b0, 3'd1, 8'h00), mk_hi(8'hFF), m); check("R11 bcast lowest", {24'h0, m}, 32'h01);
    issue(mk_lo(2'd3, 1'b0, 3'd1, 8'h00), mk_hi(8'h00), m); check("R11 others lowest", {24'h0, m}, 32'h02);
    issue(mk_lo(2'd0, 1'b1, 3'd1, 8'h00), mk_hi(8'h0C), m); check("R11 flat lowest", {24'h0, m}, 32'h04);
    issue(mk_lo(2'd0, 1'b1, 3'd0, 8'h00), mk_hi(8'h0C), m); check("R11 fixed full", {24'h0, m}, 32'h0C);
    issue(mk_lo(2'd0, 1'b1, 3'd2, 8'h00), mk_hi(8'h0C), m); check("R11 mode 2 full", {24'h0, m}, 32'h0C);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    tgt_ready = 1'b0;
    cmd_lo = mk_lo(2'd0, 1'b0, 3'd0, 8'h00); cmd_hi = mk_hi(8'd1); cmd_valid = 1'b1;
    @(negedge clk);
    check("R2 first valid", {31'h0, tgt_valid}, 32'h1);
    check("R2 first mask", {24'h0, tgt_mask}, 32'h02);
    cmd_hi = mk_hi(8'd2);
    check("R2 ready low", {31'h0, cmd_ready}, 32'h0);
    @(negedge clk);
    check("R2 hold mask", {24'h0, tgt_mask}, 32'h02);
    check("R2 hold valid", {31'h0, tgt_valid}, 32'h1);
    tgt_ready = 1'b1;
    @(negedge clk);
    check("R2 second mask", {24'h0, tgt_mask}, 32'h04);
    cmd_valid = 1'b0;
    @(negedge clk);
    check("R2 drain", {31'h0, tgt_valid}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_physical();
    t_flat();
    t_cluster();
    t_shorthand();
    t_lowest();
    t_backpressure();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule